// File: doc/BRIEF.md
# Fifteen-Source Maskable Interrupt Controller

This block collects up to fifteen numbered interrupt requests into a pending register and presents one 4-bit priority level to the processor. Source n (1 to 15) always occupies bit n of every interrupt register, and bit 0 is never used. A one-cycle pulse on a source input marks that source pending. The pending bit then stays set until software writes a 1 to the same bit of the clear register.

Software blocks sources through a mask register, in which a 1 hides the source. It can also raise any source by hand through a force register. Writes to the force register only take effect while the force-enable bit (bit 19) of the test-control register is set. The processor level is the number of the highest source that is pending or forced and not masked, or 0 when no source qualifies. In the usual assignment, source 15 is the watchdog timeout, 13 the real-time clock, 12 the general-purpose timer and 1 the masked-errors source.

Registers sit on a plain 32-bit bus with an address, a write strobe, write data and read data. Reads are combinational. A write lands on the rising clock edge. The block is pure datapath and has no state machine: every register updates in the same single clock phase.

Top module: `irqc_top`

## Requirements
- R1: After reset the pending, force and test-control registers read 0, the mask register reads 0x0000FFFE (all sources blocked), and the level output is 0.
- R2: A 1 on input bit n (1..15) of the source pulse vector in a cycle sets pending bit n at that clock edge. Input bit 0 has no effect, and pending bit 0 always reads 0.
- R3: A pending bit stays set across cycles with no clear. A write to offset 0x50 clears exactly the pending bits written as 1. Bits written as 0 leave their pending bits unchanged.
- R4: When a clear of bit n and a new pulse on source n occur in the same cycle, pending bit n ends up set.
- R5: A 1 in mask bit n (offset 0x4C, read/write) keeps source n from the level output, whether the source is pending or forced. A 0 lets the source through.
- R6: The level output equals the highest n in 1..15 for which (pending OR forced) AND NOT mask has bit n set. It is 0 when no such n exists.
- R7: A write to the force register at offset 0x54 updates it only while bit 19 of the test-control register (offset 0xD0, read/write, all 32 bits) is 1. At other times the write is ignored.
- R8: A forced bit stays set until software writes 0 to it in the force register. A write to the clear register does not change the force register.
- R9: Offset 0x48 reads the pending register, and writes to it are ignored. Offset 0x50 reads 0. Unmapped offsets read 0. Bit 0 of the mask and force registers always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Byte offset of the register accessed |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address |
| src_pulse | input | 16 | Source request pulses, bit n is source n, bit 0 ignored |
| irq_level | output | 4 | Highest unmasked active source number, 0 if none |

## Verification
The bench targets the collision of a clear write with a new pulse on the same source. A design that lets the clear win would lose that interrupt. It also writes the force register with the enable bit off. A design without the gate would raise the level anyway. Further checks confirm that a clear write leaves forced bits alone and that a masked top source yields to a lower unmasked one. A wrong priority encoder would then report the blocked source, or 0. A pulse on bit 0 must change nothing. Writes to the pending offset must leave it intact.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    localparam int DATA_W       = 32;
    localparam int ADDR_W       = 8;
    localparam int NSRC         = 16;
    localparam int LVL_W        = $clog2(NSRC);
    localparam int FORCE_EN_BIT = 19;

    localparam logic [ADDR_W-1:0] OFF_PEND = 8'h48;
    localparam logic [ADDR_W-1:0] OFF_MASK = 8'h4C;
    localparam logic [ADDR_W-1:0] OFF_CLR  = 8'h50;
    localparam logic [ADDR_W-1:0] OFF_FRC  = 8'h54;
    localparam logic [ADDR_W-1:0] OFF_TCTL = 8'hD0;
endpackage

// File: rtl/irqc_regs.sv
module irqc_regs
    import irqc_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int AW = ADDR_W,
    parameter int NS = NSRC
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_we,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic [NS-1:0] src_pulse,
    output logic [NS-1:0] pend_q,
    output logic [NS-1:0] mask_q,
    output logic [NS-1:0] force_q,
    output logic [DW-1:0] tctl_q
);
    localparam logic [NS-1:0] VALID = {{(NS-1){1'b1}}, 1'b0};
    localparam int            PADW  = DW - NS;

    logic [NS-1:0] clr_bits;
    logic          wr_mask, wr_frc, wr_tctl;

    always_comb begin
        clr_bits = (bus_we && bus_addr == OFF_CLR) ? bus_wdata[NS-1:0] : '0;
        wr_mask  = bus_we && bus_addr == OFF_MASK;
        wr_frc   = bus_we && bus_addr == OFF_FRC && tctl_q[FORCE_EN_BIT];
        wr_tctl  = bus_we && bus_addr == OFF_TCTL;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q  <= '0;
            mask_q  <= VALID;
            force_q <= '0;
            tctl_q  <= '0;
        end else begin
            // a fresh pulse wins over a clear in the same cycle
            pend_q <= ((pend_q & ~clr_bits) | src_pulse) & VALID;
            if (wr_mask) mask_q  <= bus_wdata[NS-1:0] & VALID;
            if (wr_frc)  force_q <= bus_wdata[NS-1:0] & VALID;
            if (wr_tctl) tctl_q  <= bus_wdata;
        end
    end

    always_comb begin
        case (bus_addr)
            OFF_PEND: bus_rdata = {{PADW{1'b0}}, pend_q};
            OFF_MASK: bus_rdata = {{PADW{1'b0}}, mask_q};
            OFF_FRC:  bus_rdata = {{PADW{1'b0}}, force_q};
            OFF_TCTL: bus_rdata = tctl_q;
            default:  bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/irqc_prio.sv
module irqc_prio
    import irqc_pkg::*;
#(
    parameter int NS = NSRC,
    parameter int LW = LVL_W
) (
    input  logic [NS-1:0] active,
    output logic [LW-1:0] level
);
    // ascending scan: the last hit, i.e. the highest number, is kept
    always_comb begin
        level = '0;
        for (int i = 1; i < NS; i++) begin
            if (active[i]) level = LW'(i);
        end
    end
endmodule

// File: rtl/irqc_top.sv
module irqc_top
    import irqc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NSRC-1:0]   src_pulse,
    output logic [LVL_W-1:0]  irq_level
);
    logic [NSRC-1:0]   pend_q, mask_q, force_q, active;
    logic [DATA_W-1:0] tctl_q;

    irqc_regs #(.DW(DATA_W), .AW(ADDR_W), .NS(NSRC)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .src_pulse (src_pulse),
        .pend_q    (pend_q),
        .mask_q    (mask_q),
        .force_q   (force_q),
        .tctl_q    (tctl_q)
    );

    assign active = (pend_q | force_q) & ~mask_q;

    irqc_prio #(.NS(NSRC), .LW(LVL_W)) u_prio (
        .active (active),
        .level  (irq_level)
    );
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker
    import irqc_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [NSRC-1:0]   src_pulse,
    input logic [LVL_W-1:0]  irq_level,
    input logic [NSRC-1:0]   pend_q,
    input logic [NSRC-1:0]   mask_q,
    input logic [NSRC-1:0]   force_q,
    input logic              force_en
);
    localparam logic [NSRC-1:0] VALID = {{(NSRC-1){1'b1}}, 1'b0};

    logic [NSRC-1:0] chk_active;
    assign chk_active = (pend_q | force_q) & ~mask_q & VALID;

    AST_PULSE_SETS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        (|(src_pulse & VALID)) |=> ((pend_q & $past(src_pulse & VALID)) == $past(src_pulse & VALID))); // R4

    AST_PEND_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we && bus_addr == OFF_CLR) |=> ((pend_q & $past(pend_q)) == $past(pend_q))); // R3

    AST_FORCE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == OFF_FRC && !force_en) |=> $stable(force_q)); // R7

    AST_LEVEL_IS_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_level != '0) |-> ((chk_active >> irq_level) == NSRC'(1))); // R6

    AST_LEVEL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_level == '0) |-> (chk_active == '0)); // R6

    AST_ALL_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (&mask_q[NSRC-1:1]) |-> (irq_level == '0)); // R5
endmodule

bind irqc_top irqc_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .src_pulse (src_pulse),
    .irq_level (irq_level),
    .pend_q    (pend_q),
    .mask_q    (mask_q),
    .force_q   (force_q),
    .force_en  (tctl_q[irqc_pkg::FORCE_EN_BIT])
);

// File: tb/irqc_top_bench.sv
module irqc_top_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [15:0] src_pulse = '0;
    logic [3:0]  irq_level;

    int checks = 0;
    int failures = 0;

    irqc_top u_irqc_top (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .src_pulse(src_pulse), .irq_level(irq_level)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // {mask, pulse, expected level}
    localparam logic [47:0] VEC [8] = '{
        {16'h0000, 16'h0002, 16'd1},
        {16'h0000, 16'h8002, 16'd15},
        {16'h8000, 16'h8002, 16'd1},
        {16'h0000, 16'h3000, 16'd13},
        {16'hFFFE, 16'hFFFE, 16'd0},
        {16'h0000, 16'h0001, 16'd0},
        {16'hE000, 16'hF000, 16'd12},
        {16'h0000, 16'h0400, 16'd10}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic pulse(input logic [15:0] p);
        @(negedge clk);
        src_pulse = p;
        @(negedge clk);
        src_pulse = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(8'h48, v); check("R1 pending", v, 32'h0);
        rd(8'h4C, v); check("R1 mask", v, 32'hFFFE);
        rd(8'h54, v); check("R1 force", v, 32'h0);
        rd(8'hD0, v); check("R1 testctl", v, 32'h0);
        check("R1 level", {28'h0, irq_level}, 32'h0);

        // R6 R5 R2 priority table
        for (int i = 0; i < 8; i++) begin
            wr(8'h50, 32'hFFFF);
            wr(8'h4C, {16'h0, VEC[i][47:32]});
            pulse(VEC[i][31:16]);
            #1;
            check($sformatf("R6 vector %0d", i), {28'h0, irq_level}, {16'h0, VEC[i][15:0]});
        end
        // R2 bit 0 never pends
        rd(8'h48, v); check("R2 bit0 pulse", v, 32'h0400);

        // R3 selective clear
        wr(8'h50, 32'hFFFF);
        pulse(16'h0220);
        wr(8'h50, 32'h0000);
        rd(8'h48, v); check("R3 zero clear", v, 32'h0220);
        wr(8'h50, 32'h0200);
        rd(8'h48, v); check("R3 one clear", v, 32'h0020);
        repeat (4) @(negedge clk);
        rd(8'h48, v); check("R3 hold", v, 32'h0020);

        // R4 clear and pulse collide
        wr(8'h50, 32'hFFFF);
        pulse(16'h0008);
        @(negedge clk);
        bus_addr = 8'h50; bus_we = 1'b1; bus_wdata = 32'h0008; src_pulse = 16'h0008;
        @(negedge clk);
        bus_we = 1'b0; src_pulse = '0;
        rd(8'h48, v); check("R4 pulse wins", v, 32'h0008);

        // R9 pending write ignored, clear reads 0, unmapped reads 0
        wr(8'h48, 32'hFFFF);
        rd(8'h48, v); check("R9 pending write", v, 32'h0008);
        rd(8'h50, v); check("R9 clear reads", v, 32'h0);
        rd(8'h60, v); check("R9 unmapped", v, 32'h0);
        wr(8'h50, 32'hFFFF);

        // R7 force gated by test-control bit 19
        wr(8'h4C, 32'h0);
        wr(8'h54, 32'h4000);
        rd(8'h54, v); check("R7 locked force", v, 32'h0);
        check("R7 locked level", {28'h0, irq_level}, 32'h0);
        wr(8'hD0, 32'h0008_0000);
        rd(8'hD0, v); check("R7 testctl readback", v, 32'h0008_0000);
        wr(8'h54, 32'h4001);
        rd(8'h54, v); check("R9 force bit0", v, 32'h4000);
        #1; check("R7 forced level", {28'h0, irq_level}, 32'd14);

        // R5 mask blocks a forced source
        wr(8'h4C, 32'h4000);
        #1; check("R5 forced masked", {28'h0, irq_level}, 32'd0);
        wr(8'h4C, 32'h0);

        // R8 clear does not touch force; force write 0 removes it
        wr(8'h50, 32'hFFFF);
        rd(8'h54, v); check("R8 force survives clear", v, 32'h4000);
        #1; check("R8 level kept", {28'h0, irq_level}, 32'd14);
        wr(8'h54, 32'h0);
        #1; check("R8 force removed", {28'h0, irq_level}, 32'd0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule